// File: doc/BRIEF.md
# Scatter Element Byte-Mask and Accumulate Unit

This block handles one element of a vector scatter at a time. A request carries a region base address, a signed offset into the region, the region length, an element size of two or four bytes, and an optional predicate vector with the element's index. The unit aligns the offset down to the element size, adds it to the base to form the element address, and decides for each byte of the element whether it may be written. The set of enabled bytes forms the element's bank mask.

A plain scatter writes the enabled bytes of the request data to memory in a single write. An accumulating scatter first reads the element from memory and adds the request data to it, wrapping at the element width. It then writes the sum back through the same byte enables. Requests whose element falls outside the region add the element size to a running out-of-bounds byte count. The unit accepts a new request only when it is idle.

The memory port takes byte addresses and is four lanes wide. Lane k of the read and write data belongs to address `mem_addr + k`. Read data must arrive on the cycle after `mem_rd_en`.

Top module: `scat_accum_unit`

## Requirements
- R1: With `req_word`=1 the element has 4 bytes and with `req_word`=0 it has 2 bytes. For a 2-byte element, bits 3:2 of the bank mask are always 0.
- R2: The element address on `mem_addr` is `req_base` plus `req_offset` rounded down to a multiple of the element size.
- R3: When `req_offset` is negative (bit 31 set), no byte of the element is enabled.
- R4: Byte i (lane i) is enabled only if element address + i is no greater than `req_base + req_len`. `resp_bank_mask` bit i is the enable of byte i.
- R5: When `req_pred_en`=1, byte i is also gated by bit `size*req_index + i` of `req_pred`. When `req_pred_en`=0, `req_pred` has no effect.
- R6: A plain request (`req_accum`=0) with at least one enabled byte causes exactly one memory write and no read. The write stores lane i of `req_data` at element address + i for each enabled byte and touches no other byte.
- R7: An accumulating request whose byte 0 is enabled reads the element little-endian. It writes back (old + `req_data`) modulo 2^(8*size) on the enabled bytes. The add wraps and does not saturate.
- R8: An accumulating request whose byte 0 is disabled performs no read and no write. A plain request with no enabled byte performs no write.
- R9: Each accepted request produces exactly one single-cycle `resp_valid` pulse carrying the bank mask. Outside that cycle `resp_bank_mask` is 0.
- R10: `oob_bytes` increases by the element size (2 or 4) for each accepted request whose offset is negative or whose element address exceeds `req_base + req_len`. It does not change for any other request.
- R11: `req_ready` is low from the cycle after acceptance until the response cycle ends. A request presented while `req_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Element request present |
| req_ready | output | 1 | Unit idle, request accepted when valid |
| req_base | input | 32 | Region base byte address |
| req_offset | input | 32 | Signed byte offset into the region |
| req_len | input | 32 | Region length; last legal byte is base + length |
| req_word | input | 1 | 1 = 4-byte element, 0 = 2-byte element |
| req_pred_en | input | 1 | Apply predicate vector |
| req_pred | input | 32 | Predicate bits, one per byte of the vector |
| req_index | input | 3 | Element index within the vector |
| req_accum | input | 1 | 1 = add to memory, 0 = overwrite |
| req_data | input | 32 | Element data, lane 0 in bits 7:0 |
| mem_rd_en | output | 1 | Read the element address |
| mem_wr_en | output | 1 | Write enabled lanes |
| mem_addr | output | 32 | Element byte address |
| mem_be | output | 4 | Lane write enables |
| mem_wdata | output | 32 | Write data by lane |
| mem_rdata | input | 32 | Read data by lane, one cycle after read |
| resp_valid | output | 1 | Element finished |
| resp_bank_mask | output | 4 | Byte enables of the finished element |
| oob_bytes | output | 16 | Running out-of-bounds byte count |

## Verification
Several properties are checked on every cycle, in the RTL:
- no request-side memory activity while idle, and a write with no lanes never occurs;
- a read is always followed two cycles later by the write;
- a negative offset always clears the mask, and a 2-byte element never enables lanes 2 and 3;
- the response is a one-cycle pulse;
- the out-of-bounds count only steps by 0, 2 or 4.

Only the directed scenarios can show the rest: the exact address alignment, the boundary byte at base plus length, the predicate bit selection by index, and the wrapped accumulate values in memory. The same holds for leaving untouched bytes intact and for ignoring a request that arrives while busy.

// File: rtl/scat_pkg.sv
package scat_pkg;

    localparam int ADDR_W    = 32;
    localparam int MAX_BYTES = 4;
    localparam int DATA_W    = 8 * MAX_BYTES;
    localparam int HALF_W    = 16;

    typedef logic [ADDR_W-1:0]    addr_t;
    typedef logic [MAX_BYTES-1:0] bmask_t;
    typedef logic [DATA_W-1:0]    data_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_SUM,
        ST_WRITE,
        ST_DONE
    } st_e;

    typedef struct packed {
        addr_t  addr;
        bmask_t be;
        data_t  data;
        logic   accum;
        logic   word;
    } entry_t;

    function automatic addr_t align_keep(logic word);
        return word ? ~addr_t'(3) : ~addr_t'(1);
    endfunction

    function automatic data_t wrap_add(data_t a, data_t b, logic word);
        data_t s;
        s = a + b;
        if (!word) s[DATA_W-1:HALF_W] = '0;
        return s;
    endfunction

endpackage

// File: rtl/scat_mask_gen.sv
module scat_mask_gen
    import scat_pkg::*;
#(
    parameter int IDX_W = 3,
    localparam int PRED_W = MAX_BYTES << IDX_W,
    localparam int PIDX_W = IDX_W + 2
) (
    input  addr_t              base,
    input  addr_t              offset,
    input  addr_t              len,
    input  logic               word,
    input  logic               pred_en,
    input  logic [PRED_W-1:0]  pred,
    input  logic [IDX_W-1:0]   idx,
    output addr_t              elem_addr,
    output bmask_t             be,
    output logic               oob
);

    logic            neg;
    logic [ADDR_W:0] limit;

    assign neg       = offset[ADDR_W-1];
    assign limit     = {1'b0, base} + {1'b0, len};
    assign elem_addr = base + (offset & align_keep(word));
    assign oob       = neg || ({1'b0, elem_addr} > limit);

    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
        logic [ADDR_W:0]   byte_addr;
        logic [PIDX_W-1:0] pidx;
        logic              in_size;
        logic              in_range;
        logic              pbit;

        assign byte_addr = {1'b0, elem_addr} + (ADDR_W + 1)'(i);
        assign in_size   = word || (i < 2);
        assign in_range  = !neg && (byte_addr <= limit);
        assign pidx      = word ? {idx, 2'(i)} : {1'b0, idx, 1'(i)};
        assign pbit      = pred[pidx];
        assign be[i]     = in_size && in_range && (!pred_en || pbit);
    end

endmodule

// File: rtl/scat_oob_counter.sv
module scat_oob_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             word,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (hit) begin
            count <= count + (word ? CNT_W'(4) : CNT_W'(2));
        end
    end

    assert_oob_step_R10: assert property (@(posedge clk) disable iff (rst)
        (count == $past(count)) ||
        (count == $past(count) + CNT_W'(2)) ||
        (count == $past(count) + CNT_W'(4)));

endmodule

// File: rtl/scat_rmw_ctrl.sv
module scat_rmw_ctrl
    import scat_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  entry_t req_ent,
    output logic   idle,
    output logic   mem_rd_en,
    output logic   mem_wr_en,
    output addr_t  mem_addr,
    output bmask_t mem_be,
    output data_t  mem_wdata,
    input  data_t  mem_rdata,
    output logic   resp_valid,
    output bmask_t resp_mask
);

    st_e    st;
    entry_t ent;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            ent <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        ent <= req_ent;
                        if (req_ent.accum)
                            st <= req_ent.be[0] ? ST_READ : ST_DONE;
                        else
                            st <= (|req_ent.be) ? ST_WRITE : ST_DONE;
                    end
                end
                ST_READ:  st <= ST_SUM;
                ST_SUM: begin
                    ent.data <= wrap_add(mem_rdata, ent.data, ent.word);
                    st       <= ST_WRITE;
                end
                ST_WRITE: st <= ST_DONE;
                ST_DONE: begin
                    ent <= '0;
                    st  <= ST_IDLE;
                end
                default:  st <= ST_IDLE;
            endcase
        end
    end

    assign idle       = (st == ST_IDLE);
    assign mem_rd_en  = (st == ST_READ);
    assign mem_wr_en  = (st == ST_WRITE);
    assign mem_addr   = ent.addr;
    assign mem_be     = mem_wr_en ? ent.be : '0;
    assign mem_wdata  = ent.data;
    assign resp_valid = (st == ST_DONE);
    assign resp_mask  = resp_valid ? ent.be : '0;

    assert_wr_has_lanes_R8: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_be != '0));

    assert_read_then_write_R7: assert property (@(posedge clk) disable iff (rst)
        $past(mem_rd_en, 2) |-> mem_wr_en);

    assert_read_gap_R7: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_wr_en && !mem_rd_en);

    assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

endmodule

// File: rtl/scat_accum_unit.sv
module scat_accum_unit
    import scat_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int CNT_W = 16,
    localparam int PRED_W = MAX_BYTES << IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [ADDR_W-1:0]    req_offset,
    input  logic [ADDR_W-1:0]    req_len,
    input  logic                 req_word,
    input  logic                 req_pred_en,
    input  logic [PRED_W-1:0]    req_pred,
    input  logic [IDX_W-1:0]     req_index,
    input  logic                 req_accum,
    input  logic [DATA_W-1:0]    req_data,
    output logic                 mem_rd_en,
    output logic                 mem_wr_en,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [MAX_BYTES-1:0] mem_be,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 resp_valid,
    output logic [MAX_BYTES-1:0] resp_bank_mask,
    output logic [CNT_W-1:0]     oob_bytes
);

    addr_t  gen_addr;
    bmask_t gen_be;
    logic   gen_oob;
    logic   idle;
    logic   fire;
    entry_t req_ent;

    scat_mask_gen #(.IDX_W(IDX_W)) u_mask (
        .base      (req_base),
        .offset    (req_offset),
        .len       (req_len),
        .word      (req_word),
        .pred_en   (req_pred_en),
        .pred      (req_pred),
        .idx       (req_index),
        .elem_addr (gen_addr),
        .be        (gen_be),
        .oob       (gen_oob)
    );

    assign req_ready = idle;
    assign fire      = req_valid && idle;

    always_comb begin
        req_ent.addr  = gen_addr;
        req_ent.be    = gen_be;
        req_ent.data  = req_data;
        req_ent.accum = req_accum;
        req_ent.word  = req_word;
    end

    scat_rmw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .accept     (fire),
        .req_ent    (req_ent),
        .idle       (idle),
        .mem_rd_en  (mem_rd_en),
        .mem_wr_en  (mem_wr_en),
        .mem_addr   (mem_addr),
        .mem_be     (mem_be),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .resp_valid (resp_valid),
        .resp_mask  (resp_bank_mask)
    );

    scat_oob_counter #(.CNT_W(CNT_W)) u_oob (
        .clk   (clk),
        .rst   (rst),
        .hit   (fire && gen_oob),
        .word  (req_word),
        .count (oob_bytes)
    );

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_rd_en && !mem_wr_en && !resp_valid);

    assert_half_upper_R1: assert property (@(posedge clk) disable iff (rst)
        (fire && !req_word) |=> !u_ctrl.ent.be[3] && !u_ctrl.ent.be[2]);

    assert_neg_offset_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_offset[ADDR_W-1]) |-> (gen_be == '0) && gen_oob);

endmodule

// File: tb/scat_accum_unit_bench.sv
module scat_accum_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_base = '0, req_offset = '0, req_len = '0;
    logic        req_word = 1'b0, req_pred_en = 1'b0, req_accum = 1'b0;
    logic [31:0] req_pred = '0;
    logic [2:0]  req_index = '0;
    logic [31:0] req_data = '0;
    logic        mem_rd_en, mem_wr_en;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        resp_valid;
    logic [3:0]  resp_bank_mask;
    logic [15:0] oob_bytes;

    always #2 clk = ~clk;

    scat_accum_unit u_scat_accum_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_offset(req_offset), .req_len(req_len),
        .req_word(req_word), .req_pred_en(req_pred_en), .req_pred(req_pred),
        .req_index(req_index), .req_accum(req_accum), .req_data(req_data),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_bank_mask(resp_bank_mask),
        .oob_bytes(oob_bytes)
    );

    logic [7:0]  mem [0:255];
    logic        poke_en = 1'b0;
    logic [7:0]  poke_addr = '0;
    logic [31:0] poke_data = '0;
    int          cnt_rd = 0, cnt_wr = 0, cnt_resp = 0;
    int          tests = 0, fails = 0;
    int          exp_oob = 0;
    bit          done = 0;

    initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    always @(posedge clk) begin
        if (poke_en)
            for (int k = 0; k < 4; k++) mem[poke_addr + 8'(k)] <= poke_data[8*k +: 8];
        if (mem_rd_en) begin
            mem_rdata <= {mem[mem_addr[7:0] + 8'd3], mem[mem_addr[7:0] + 8'd2],
                          mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};
            cnt_rd <= cnt_rd + 1;
        end
        if (mem_wr_en) begin
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem[mem_addr[7:0] + 8'(k)] <= mem_wdata[8*k +: 8];
            cnt_wr <= cnt_wr + 1;
        end
        if (resp_valid) cnt_resp <= cnt_resp + 1;
    end

    function automatic logic [31:0] peek32(int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    function automatic logic [3:0] exp_mask(int base, int off, int len, bit word,
                                            bit pen, logic [31:0] pred, int idx);
        logic [3:0] m;
        int sz, a;
        m  = '0;
        sz = word ? 4 : 2;
        if (off < 0) return m;
        a = base + (off & ~(sz - 1));
        for (int i = 0; i < sz; i++)
            if ((a + i <= base + len) && (!pen || pred[sz*idx + i])) m[i] = 1'b1;
        return m;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(int a, logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = 8'(a); poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    // Issues one request and waits for its response; returns mask and counts.
    task automatic run_req(int base, int off, int len, bit word, bit pen,
                           logic [31:0] pred, int idx, bit acc, logic [31:0] data,
                           output logic [3:0] mask, output int drd, output int dwr);
        int rd0, wr0;
        bit seen;
        @(negedge clk);
        rd0 = cnt_rd; wr0 = cnt_wr;
        req_base = 32'(base); req_offset = 32'(off); req_len = 32'(len);
        req_word = word; req_pred_en = pen; req_pred = pred; req_index = 3'(idx);
        req_accum = acc; req_data = data; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0;
        mask = '0;
        for (int t = 0; t < 12 && !seen; t++) begin
            if (resp_valid) begin
                mask = resp_bank_mask;
                seen = 1;
            end else begin
                @(negedge clk);
            end
        end
        check(seen, "R9 response pulse seen", 32'(seen), 32'd1);
        @(negedge clk);
        check(!resp_valid && resp_bank_mask == 0, "R9 mask cleared after response",
              {27'd0, resp_valid, resp_bank_mask}, 32'd0);
        drd = cnt_rd - rd0;
        dwr = cnt_wr - wr0;
    endtask

    task automatic t_reset;
        check(req_ready && !resp_valid && resp_bank_mask == 0 && oob_bytes == 0 &&
              !mem_rd_en && !mem_wr_en, "R11 reset state",
              {16'(oob_bytes), 8'(resp_bank_mask), 4'd0, req_ready, resp_valid,
               mem_rd_en, mem_wr_en}, 32'h0000_0008);
    endtask

    task automatic t_plain_word;
        logic [3:0] m; int rd, wr;
        run_req(32'h40, 8, 32'h20, 1, 0, 0, 0, 0, 32'h1122_3344, m, rd, wr);
        check(m == 4'hF, "R1 word mask", 32'(m), 32'hF);
        check(peek32(32'h48) == 32'h1122_3344, "R6 R2 word stored",
              peek32(32'h48), 32'h1122_3344);
        check(rd == 0 && wr == 1, "R6 one write no read", 32'(rd*16 + wr), 32'd1);
    endtask

    task automatic t_plain_half_align;
        logic [3:0] m; int rd, wr;
        poke(32'h64, 32'hAAAA_AAAA);
        run_req(32'h60, 5, 32'h10, 0, 0, 0, 0, 0, 32'h7788_5566, m, rd, wr);
        check(m == 4'h3, "R1 halfword mask", 32'(m), 32'h3);
        check(peek32(32'h64) == 32'hAAAA_5566, "R2 offset rounded to 4, upper kept",
              peek32(32'h64), 32'hAAAA_5566);
    endtask

    task automatic t_boundary;
        logic [3:0] m; int rd, wr;
        run_req(32'h80, 32'h0C, 32'h0D, 1, 0, 0, 0, 0, 32'hDDCC_BBAA, m, rd, wr);
        check(m == exp_mask(32'h80, 32'h0C, 32'h0D, 1, 0, 0, 0) && m == 4'h3,
              "R4 last byte at base+len", 32'(m), 32'h3);
        check(peek32(32'h8C) == 32'h0000_BBAA, "R4 bytes past limit untouched",
              peek32(32'h8C), 32'h0000_BBAA);
    endtask

    task automatic t_negative;
        logic [3:0] m; int rd, wr;
        run_req(32'h90, -4, 32'h40, 1, 0, 0, 0, 0, 32'hFFFF_FFFF, m, rd, wr);
        exp_oob += 4;
        check(m == 0, "R3 negative offset mask", 32'(m), 32'h0);
        check(wr == 0 && peek32(32'h8C) == 32'h0000_BBAA, "R8 no write on empty mask",
              32'(wr), 32'd0);
        check(oob_bytes == 16'(exp_oob), "R10 word oob adds 4",
              32'(oob_bytes), 32'(exp_oob));
    endtask

    task automatic t_beyond;
        logic [3:0] m; int rd, wr;
        run_req(32'h80, 32'h20, 32'h10, 0, 0, 0, 0, 0, 32'h1234, m, rd, wr);
        exp_oob += 2;
        check(m == 0 && wr == 0, "R4 element past region", 32'(m), 32'h0);
        check(oob_bytes == 16'(exp_oob), "R10 half oob adds 2",
              32'(oob_bytes), 32'(exp_oob));
        run_req(32'h80, 32'h0C, 32'h0D, 1, 0, 0, 0, 0, 32'hDDCC_BBAA, m, rd, wr);
        check(oob_bytes == 16'(exp_oob), "R10 partial element not counted",
              32'(oob_bytes), 32'(exp_oob));
    endtask

    task automatic t_predicate;
        logic [3:0] m; int rd, wr;
        logic [31:0] p;
        p = 32'h0000_0A00;
        run_req(32'h00, 32'h10, 32'h40, 1, 1, p, 2, 0, 32'h4433_2211, m, rd, wr);
        check(m == 4'hA, "R5 word predicate index 2", 32'(m), 32'hA);
        check(peek32(32'h10) == 32'h4400_2200, "R5 predicated bytes only",
              peek32(32'h10), 32'h4400_2200);
        run_req(32'h00, 32'h20, 32'h40, 1, 0, 32'h0, 2, 0, 32'h0102_0304, m, rd, wr);
        check(m == 4'hF, "R5 predicate ignored when off", 32'(m), 32'hF);
        p = 32'h0000_0080;
        run_req(32'h00, 32'h30, 32'h40, 0, 1, p, 3, 0, 32'h0000_BEEF, m, rd, wr);
        check(m == 4'h2 && m == exp_mask(0, 32'h30, 32'h40, 0, 1, p, 3),
              "R5 halfword predicate index 3", 32'(m), 32'h2);
    endtask

    task automatic t_accumulate;
        logic [3:0] m; int rd, wr;
        poke(32'hA0, 32'h0000_00FF);
        run_req(32'hA0, 0, 32'h20, 1, 0, 0, 0, 1, 32'h0000_0001, m, rd, wr);
        check(peek32(32'hA0) == 32'h0000_0100, "R7 word carry across bytes",
              peek32(32'hA0), 32'h0000_0100);
        check(rd == 1 && wr == 1, "R7 one read one write", 32'(rd*16 + wr), 32'h11);
        poke(32'hA4, 32'hFFFF_FFFF);
        run_req(32'hA0, 4, 32'h20, 1, 0, 0, 0, 1, 32'h0000_0002, m, rd, wr);
        check(peek32(32'hA4) == 32'h0000_0001, "R7 word wraps",
              peek32(32'hA4), 32'h0000_0001);
        poke(32'hB0, 32'h5555_FFFF);
        run_req(32'hB0, 0, 32'h20, 0, 0, 0, 0, 1, 32'h0000_0003, m, rd, wr);
        check(peek32(32'hB0) == 32'h5555_0002, "R7 halfword wraps, upper kept",
              peek32(32'hB0), 32'h5555_0002);
    endtask

    task automatic t_accum_skip;
        logic [3:0] m; int rd, wr;
        poke(32'hB8, 32'h1111_1111);
        run_req(32'hB8, 0, 32'h20, 1, 1, 32'h0000_000E, 0, 1, 32'h0101_0101, m, rd, wr);
        check(m == 4'hE, "R8 mask still reported", 32'(m), 32'hE);
        check(rd == 0 && wr == 0 && peek32(32'hB8) == 32'h1111_1111,
              "R8 no accumulate without byte 0", peek32(32'hB8), 32'h1111_1111);
    endtask

    task automatic t_busy;
        int r0;
        bit seen;
        @(negedge clk);
        r0 = cnt_resp;
        req_base = 32'hD0; req_offset = 0; req_len = 32'h10; req_word = 1;
        req_pred_en = 0; req_accum = 1; req_data = 32'h1; req_valid = 1'b1;
        @(negedge clk);
        check(!req_ready, "R11 busy after accept", 32'(req_ready), 32'd0);
        req_base = 32'hC0; req_accum = 0; req_data = 32'hDEAD_BEEF;
        seen = 0;
        for (int t = 0; t < 12 && !seen; t++) begin
            if (resp_valid) seen = 1;
            else @(negedge clk);
        end
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        check(cnt_resp - r0 == 1, "R11 one response only", 32'(cnt_resp - r0), 32'd1);
        check(peek32(32'hC0) == 32'h0, "R11 busy request ignored",
              peek32(32'hC0), 32'h0);
        check(peek32(32'hD0) == 32'h1, "R7 accepted accumulate done",
              peek32(32'hD0), 32'h1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain_word();
        t_plain_half_align();
        t_boundary();
        t_negative();
        t_beyond();
        t_predicate();
        t_accumulate();
        t_accum_skip();
        t_busy();
        finish_run();
    end

    initial begin
        #(4 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

endmodule